// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Sequencer

This block is the central sequencer for a crossing where a busy highway meets a lightly used farm road. It owns the six lamp outputs, a red, amber and green lamp for each road. Its inputs are a single car-waiting flag from the farm road and two elapsed flags, one from a long-interval timer and one from a short-interval timer. The timers are separate blocks. The sequencer drives them only through command lines: it starts, acknowledges and clears the long timer, and it starts the short timer.

The highway keeps green for at least one long interval. It yields only when a farm car is waiting and the long interval has run out. Each change of right-of-way passes through an amber phase that lasts one short interval.

The farm road keeps green while cars keep arriving, but never for more than one long interval. When the side road clears before the long interval ends, the sequencer clears the long timer at once and moves to farm amber. It does not wait out the rest of the long interval.

Top module: `crossing_ctrl`

## Requirements
- R1: While reset is high and on release, the highway shows green and the farm road shows red, and all four timer command outputs are low.
- R2: In every cycle exactly one lamp of each road is lit, and the two green lamps are never lit together.
- R3: Highway green is left only in a cycle where `car_wait` and `long_done` are both high. The next cycle then shows highway amber with farm red, and `long_ack` and `short_start` are high.
- R4: While highway green is held, `long_start` is high from the first cycle after reset onward.
- R5: Highway amber moves to highway red with farm green after a cycle in which `short_done` is high, and `long_start` is high in that first farm-green cycle.
- R6: In farm green, a high `long_done` moves the sequencer to farm amber with highway red, pulsing `long_ack` and `short_start`. This holds whatever `car_wait` shows.
- R7: In farm green with `long_done` low, a low `car_wait` moves the sequencer to farm amber, pulsing `long_clear` and `short_start` and leaving `long_ack` low.
- R8: Farm green is held while `car_wait` is high and `long_done` is low, with `long_start` high and the other commands low.
- R9: Farm amber returns to highway green with farm red after a cycle in which `short_done` is high, and `long_start` is high in that first highway-green cycle.
- R10: `long_ack`, `long_clear` and `short_start` are one-cycle pulses. All four commands are low while an amber phase is held.
- R11: `short_done` has no effect during a green phase, and `car_wait` and `long_done` have no effect during an amber phase. Lamps and commands follow the held phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| car_wait | input | 1 | A farm-road car is waiting |
| long_done | input | 1 | Long interval has elapsed |
| short_done | input | 1 | Short interval has elapsed |
| hw_red | output | 1 | Highway red lamp |
| hw_amber | output | 1 | Highway amber lamp |
| hw_go | output | 1 | Highway green lamp |
| fm_red | output | 1 | Farm-road red lamp |
| fm_amber | output | 1 | Farm-road amber lamp |
| fm_go | output | 1 | Farm-road green lamp |
| long_start | output | 1 | Run command to the long timer, held during green |
| long_ack | output | 1 | Pulse returning an elapsed long timer to idle |
| long_clear | output | 1 | Pulse forcing the long timer to idle immediately |
| short_start | output | 1 | Pulse starting the short timer |

## Verification
In farm green, the car leaving and the long interval expiring can coincide in one cycle. The bench drives `car_wait` low and `long_done` high together and expects the acknowledge pulse rather than the clear pulse.

A second overlap is a timer flag that arrives in the wrong phase, for example `short_done` during green or `long_done` during amber. The bench injects these flags and judges the result against its own phase model at every clock.

A long pseudo-random run then mixes all three inputs so that such coincidences recur at many points of the cycle.

// File: rtl/crossing_pkg.sv
package crossing_pkg;

    localparam int PHASE_W = 3;

    // Power-up phase must encode as all zeros; the remaining codes are free.
    typedef enum logic [PHASE_W-1:0] {
        PH_HWY_GO  = 3'b000,
        PH_HWY_AMB = 3'b100,
        PH_FRM_GO  = 3'b110,
        PH_FRM_AMB = 3'b010
    } phase_e;

    typedef struct packed {
        logic red;
        logic amber;
        logic go;
    } lamp_t;

    typedef struct packed {
        logic long_start;
        logic long_ack;
        logic long_clear;
        logic short_start;
    } tcmd_t;

    localparam lamp_t LAMP_RED   = '{red: 1'b1, amber: 1'b0, go: 1'b0};
    localparam lamp_t LAMP_AMBER = '{red: 1'b0, amber: 1'b1, go: 1'b0};
    localparam lamp_t LAMP_GO    = '{red: 1'b0, amber: 1'b0, go: 1'b1};
    localparam tcmd_t TCMD_IDLE  = '0;

    function automatic logic is_green(input phase_e p);
        return (p == PH_HWY_GO) || (p == PH_FRM_GO);
    endfunction

    function automatic logic is_amber(input phase_e p);
        return (p == PH_HWY_AMB) || (p == PH_FRM_AMB);
    endfunction

endpackage

// File: rtl/crossing_phase.sv
module crossing_phase
    import crossing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   car_wait,
    input  logic   long_done,
    input  logic   short_done,
    output phase_e cur,
    output phase_e nxt
);

    always_comb begin
        nxt = cur;
        case (cur)
            PH_HWY_GO:  if (car_wait && long_done) nxt = PH_HWY_AMB;
            PH_HWY_AMB: if (short_done)            nxt = PH_FRM_GO;
            PH_FRM_GO:  if (long_done || !car_wait) nxt = PH_FRM_AMB;
            PH_FRM_AMB: if (short_done)            nxt = PH_HWY_GO;
            default:                               nxt = PH_HWY_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= PH_HWY_GO;
        else     cur <= nxt;
    end

endmodule

// File: rtl/crossing_lamp_dec.sv
module crossing_lamp_dec
    import crossing_pkg::*;
(
    input  phase_e ph,
    output lamp_t  hwy,
    output lamp_t  frm
);

    always_comb begin
        case (ph)
            PH_HWY_GO:  begin hwy = LAMP_GO;    frm = LAMP_RED;   end
            PH_HWY_AMB: begin hwy = LAMP_AMBER; frm = LAMP_RED;   end
            PH_FRM_GO:  begin hwy = LAMP_RED;   frm = LAMP_GO;    end
            PH_FRM_AMB: begin hwy = LAMP_RED;   frm = LAMP_AMBER; end
            default:    begin hwy = LAMP_RED;   frm = LAMP_RED;   end
        endcase
    end

endmodule

// File: rtl/crossing_tcmd.sv
module crossing_tcmd
    import crossing_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e cur,
    input  phase_e nxt,
    input  logic   long_done,
    output tcmd_t  cmd
);

    tcmd_t cmd_d;
    logic  leaving_green;

    assign leaving_green = is_green(cur) && is_amber(nxt);

    always_comb begin
        cmd_d             = TCMD_IDLE;
        cmd_d.long_start  = is_green(nxt);
        cmd_d.short_start = leaving_green;
        // An elapsed long timer is acknowledged; an early farm exit clears it.
        cmd_d.long_ack    = leaving_green && ((cur == PH_HWY_GO) || long_done);
        cmd_d.long_clear  = leaving_green && (cur == PH_FRM_GO) && !long_done;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd <= TCMD_IDLE;
        else     cmd <= cmd_d;
    end

endmodule

// File: rtl/crossing_ctrl.sv
module crossing_ctrl
    import crossing_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic car_wait,
    input  logic long_done,
    input  logic short_done,
    output logic hw_red,
    output logic hw_amber,
    output logic hw_go,
    output logic fm_red,
    output logic fm_amber,
    output logic fm_go,
    output logic long_start,
    output logic long_ack,
    output logic long_clear,
    output logic short_start
);

    phase_e cur_ph;
    phase_e nxt_ph;
    lamp_t  hwy_l;
    lamp_t  frm_l;
    tcmd_t  cmd;

    crossing_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .car_wait   (car_wait),
        .long_done  (long_done),
        .short_done (short_done),
        .cur        (cur_ph),
        .nxt        (nxt_ph)
    );

    crossing_lamp_dec u_lamps (
        .ph  (cur_ph),
        .hwy (hwy_l),
        .frm (frm_l)
    );

    crossing_tcmd u_tcmd (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur_ph),
        .nxt       (nxt_ph),
        .long_done (long_done),
        .cmd       (cmd)
    );

    assign hw_red      = hwy_l.red;
    assign hw_amber    = hwy_l.amber;
    assign hw_go       = hwy_l.go;
    assign fm_red      = frm_l.red;
    assign fm_amber    = frm_l.amber;
    assign fm_go       = frm_l.go;
    assign long_start  = cmd.long_start;
    assign long_ack    = cmd.long_ack;
    assign long_clear  = cmd.long_clear;
    assign short_start = cmd.short_start;

endmodule

// File: rtl/crossing_ctrl_chk.sv
module crossing_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic car_wait,
    input logic long_done,
    input logic short_done,
    input logic hw_red,
    input logic hw_amber,
    input logic hw_go,
    input logic fm_red,
    input logic fm_amber,
    input logic fm_go,
    input logic long_start,
    input logic long_ack,
    input logic long_clear,
    input logic short_start
);

    a_r2_hwy_one_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({hw_red, hw_amber, hw_go}) == 1);

    a_r2_frm_one_lamp: assert property (@(posedge clk) disable iff (rst)
        $countones({fm_red, fm_amber, fm_go}) == 1);

    a_r2_no_dual_green: assert property (@(posedge clk) disable iff (rst)
        !(hw_go && fm_go));

    a_r3_hwy_yield: assert property (@(posedge clk) disable iff (rst)
        hw_go && car_wait && long_done |=> hw_amber && fm_red && long_ack && short_start);

    a_r3_hwy_stays: assert property (@(posedge clk) disable iff (rst)
        hw_go && !(car_wait && long_done) |=> hw_go);

    a_r4_hwy_long_run: assert property (@(posedge clk) disable iff (rst)
        hw_go && !(car_wait && long_done) |=> long_start);

    a_r5_to_farm_go: assert property (@(posedge clk) disable iff (rst)
        hw_amber && short_done |=> fm_go && hw_red && long_start);

    a_r6_farm_expire: assert property (@(posedge clk) disable iff (rst)
        fm_go && long_done |=> fm_amber && long_ack && short_start && !long_clear);

    a_r7_farm_clear: assert property (@(posedge clk) disable iff (rst)
        fm_go && !long_done && !car_wait |=> fm_amber && long_clear && short_start && !long_ack);

    a_r8_farm_hold: assert property (@(posedge clk) disable iff (rst)
        fm_go && car_wait && !long_done |=> fm_go && long_start);

    a_r9_to_hwy_go: assert property (@(posedge clk) disable iff (rst)
        fm_amber && short_done |=> hw_go && fm_red && long_start);

    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        long_ack |=> !long_ack);

    a_r10_clear_pulse: assert property (@(posedge clk) disable iff (rst)
        long_clear |=> !long_clear);

    a_r10_short_pulse: assert property (@(posedge clk) disable iff (rst)
        short_start |=> !short_start);

    a_r11_amber_hold: assert property (@(posedge clk) disable iff (rst)
        (hw_amber || fm_amber) && !short_done |=> $stable({hw_amber, fm_amber}));

endmodule

bind crossing_ctrl crossing_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .car_wait    (car_wait),
    .long_done   (long_done),
    .short_done  (short_done),
    .hw_red      (hw_red),
    .hw_amber    (hw_amber),
    .hw_go       (hw_go),
    .fm_red      (fm_red),
    .fm_amber    (fm_amber),
    .fm_go       (fm_go),
    .long_start  (long_start),
    .long_ack    (long_ack),
    .long_clear  (long_clear),
    .short_start (short_start)
);

// File: tb/crossing_ctrl_test.sv
module crossing_ctrl_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_wait = 1'b0;
    logic long_done = 1'b0;
    logic short_done = 1'b0;
    logic hw_red, hw_amber, hw_go, fm_red, fm_amber, fm_go;
    logic long_start, long_ack, long_clear, short_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model: 0 highway green, 1 highway amber, 2 farm green, 3 farm amber
    int    m_st = 0;
    logic  m_ls = 1'b0, m_la = 1'b0, m_lc = 1'b0, m_ss = 1'b0;
    bit    m_entered = 1'b0;
    string m_tag = "R1";

    always #2 clk = ~clk;

    crossing_ctrl uut (
        .clk(clk), .rst(rst), .car_wait(car_wait), .long_done(long_done),
        .short_done(short_done), .hw_red(hw_red), .hw_amber(hw_amber),
        .hw_go(hw_go), .fm_red(fm_red), .fm_amber(fm_amber), .fm_go(fm_go),
        .long_start(long_start), .long_ack(long_ack), .long_clear(long_clear),
        .short_start(short_start)
    );

    function automatic logic [9:0] expected_vec();
        logic [5:0] lamps;
        case (m_st)
            0:       lamps = 6'b001_100;
            1:       lamps = 6'b010_100;
            2:       lamps = 6'b100_001;
            default: lamps = 6'b100_010;
        endcase
        return {lamps, m_ls, m_la, m_lc, m_ss};
    endfunction

    task automatic check_now();
        logic [9:0] act;
        logic [9:0] exp;
        act = {hw_red, hw_amber, hw_go, fm_red, fm_amber, fm_go,
               long_start, long_ack, long_clear, short_start};
        exp = expected_vec();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s outputs actual %b expected %b at %0t", m_tag, act, exp, $time);
        end
        checks++;
        if (!($countones(act[9:7]) == 1 && $countones(act[6:4]) == 1 && !(act[7] && act[4]))) begin
            errors++;
            $display("FAIL R2 lamps actual %b expected one lamp per road", act[9:4]);
        end
    endtask

    task automatic model_step(input logic c, input logic ld, input logic sd);
        bit was_entry;
        was_entry = m_entered;
        m_entered = 1'b0;
        m_ls = 1'b0; m_la = 1'b0; m_lc = 1'b0; m_ss = 1'b0;
        case (m_st)
            0: if (c && ld) begin
                   m_st = 1; m_la = 1'b1; m_ss = 1'b1; m_entered = 1'b1; m_tag = "R3";
               end else begin
                   m_ls = 1'b1;
                   m_tag = sd ? "R11" : ((c || ld) ? "R3" : "R4");
               end
            1: if (sd) begin
                   m_st = 2; m_ls = 1'b1; m_tag = "R5";
               end else m_tag = was_entry ? "R10" : "R11";
            2: if (ld) begin
                   m_st = 3; m_la = 1'b1; m_ss = 1'b1; m_entered = 1'b1; m_tag = "R6";
               end else if (!c) begin
                   m_st = 3; m_lc = 1'b1; m_ss = 1'b1; m_entered = 1'b1; m_tag = "R7";
               end else begin
                   m_ls = 1'b1; m_tag = sd ? "R11" : "R8";
               end
            default: if (sd) begin
                   m_st = 0; m_ls = 1'b1; m_tag = "R9";
               end else m_tag = was_entry ? "R10" : "R11";
        endcase
    endtask

    // check the current outputs, then present new inputs for the next edge
    task automatic step(input logic c, input logic ld, input logic sd);
        @(negedge clk);
        check_now();
        car_wait = c; long_done = ld; short_done = sd;
        model_step(c, ld, sd);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        m_tag = "R1";
        check_now();
        rst = 1'b0;
        model_step(1'b0, 1'b0, 1'b0);

        // R4 and R11: highway green held; stray short flag ignored
        step(0, 0, 0);
        step(0, 0, 1);
        step(1, 0, 0);   // R3: car alone does not yield
        step(0, 1, 0);   // R3: expiry alone does not yield
        step(1, 1, 0);   // R3: both -> amber
        step(1, 1, 0);   // R11: long flag ignored in amber
        step(0, 0, 0);
        step(1, 0, 1);   // R5: to farm green
        step(1, 0, 0);   // R8 hold
        step(1, 0, 1);   // R11: short flag ignored in green
        step(0, 0, 0);   // R7: car gone -> clear
        step(0, 0, 0);
        step(0, 0, 1);   // R9: back to highway green
        step(1, 1, 0);
        step(0, 0, 1);
        step(1, 0, 0);
        step(1, 1, 0);   // R6: expiry with car present
        step(0, 0, 1);
        step(1, 1, 0);
        step(0, 0, 1);
        step(0, 1, 0);   // R6: coincident car drop and expiry -> acknowledge
        step(1, 0, 1);
        step(0, 0, 0);

        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[3], lfsr[5] & lfsr[1], lfsr[7] & lfsr[2]);
        end
        @(negedge clk);
        check_now();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule